// File: doc/BRIEF.md
# Three-Bus Prioritized Interrupt Arbiter

This block arbitrates among 27 interrupt request lines arranged as three 9-lane buses: a high-rank bus, a middle-rank bus and a low-rank bus. A 9-bit lane-enable vector gates each lane position across all three buses at once. A cleared enable bit hides that lane's requests on every bus. The block finds the highest-ranked bus that still has an enabled request. Within that bus it picks the highest lane number, and it reports that lane as a 4-bit binary index.

The chosen lane index is shared by all three buses. Each bus gets its own acknowledge flag, and a flag is raised for every bus that holds an enabled request on the chosen lane. Two or three buses can therefore be acknowledged together. An example: high-rank lanes 4 and 2, middle-rank lane 6 and low-rank lane 4 are pending. The result is index 4, with the high-rank and low-rank flags set.

A parameter picks between a purely combinational result and a result registered by one clock stage. The registered form has a synchronous, active-high reset.

Top module: `irq_tri_arbiter`

## Requirements
- R1: When lane_en[i] is 0, req_hi[i], req_mid[i] and req_lo[i] have no effect on any output, exactly as if they were 0.
- R2: If req_hi has any enabled bit, the index comes from req_hi. Otherwise, if req_mid has any enabled bit, it comes from req_mid. Otherwise it comes from req_lo. This holds regardless of which lane numbers are set.
- R3: Within the chosen bus the index is the highest enabled set lane (lane 8 beats lane 0).
- R4: win_idx is the chosen lane as unsigned binary, so its value is 0 to 8 and it never exceeds 8.
- R5: ack_hi, ack_mid and ack_lo are each 1 exactly when that bus has an enabled request on lane win_idx.
- R6: With high lanes 4 and 2, middle lane 6 and low lane 4 requested and every lane enabled, the outputs are ack_hi=1, ack_mid=0, ack_lo=1 and win_idx=4.
- R7: With no enabled request on any bus, all three acks are 0 and win_idx is 0.
- R8: With REG_OUT=1, the outputs show the result for the inputs sampled at the previous rising clock edge. A clock edge with rst=1 clears all outputs to 0.
- R9: With REG_OUT=0, the outputs follow the inputs with no clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset for the output register |
| req_hi | input | 9 | High-rank request bus |
| req_mid | input | 9 | Middle-rank request bus |
| req_lo | input | 9 | Low-rank request bus |
| lane_en | input | 9 | Per-lane enable shared by all buses |
| ack_hi | output | 1 | High-rank bus acknowledged |
| ack_mid | output | 1 | Middle-rank bus acknowledged |
| ack_lo | output | 1 | Low-rank bus acknowledged |
| win_idx | output | 4 | Winning lane index, binary |

## Verification
The bench drives every lone request with three enable patterns: all lanes on, only that lane on, and only that lane off. A design that ignored enables, or that masked the wrong lane, would acknowledge a hidden request. All 729 ordered request pairs are swept next, which exposes an inverted rank order or a lowest-lane-first encoder through a wrong index. It also exposes a design that acknowledges only the winning bus instead of every bus that shares the lane. Cleared enables with all requests set, all inputs set, and random vectors cover the idle-zero case and the mixed cases. A second, registered instance is checked one cycle late and under reset, to catch a missing or duplicated pipeline stage.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int unsigned LANE_COUNT_DEF = 9;
    localparam int unsigned BUS_COUNT      = 3;

    // Rank of each request bus; a lower value wins.
    typedef enum logic [1:0] {
        RANK_HI  = 2'd0,
        RANK_MID = 2'd1,
        RANK_LO  = 2'd2
    } bus_rank_e;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned LANES = 9,
    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Later iterations override earlier ones, so the top set lane wins.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_bus_pick.sv
module irq_bus_pick #(
    parameter int unsigned BUSES = 3,
    parameter int unsigned IDX_W = 4
) (
    input  logic [BUSES-1:0][IDX_W-1:0] bus_idx,
    input  logic [BUSES-1:0]            bus_any,
    output logic [IDX_W-1:0]            pick_idx
);

    // Bus 0 has top rank: walk from the lowest rank upward, overriding.
    always_comb begin
        pick_idx = '0;
        for (int b = BUSES - 1; b >= 0; b--) begin
            if (bus_any[b]) begin
                pick_idx = bus_idx[b];
            end
        end
    end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter bit          REG_OUT = 1'b0,
    parameter int unsigned W       = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/irq_tri_arbiter.sv
module irq_tri_arbiter
    import irq_arb_pkg::*;
#(
    parameter int unsigned LANES   = LANE_COUNT_DEF,
    parameter bit          REG_OUT = 1'b0,
    localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] req_hi,
    input  logic [LANES-1:0] req_mid,
    input  logic [LANES-1:0] req_lo,
    input  logic [LANES-1:0] lane_en,
    output logic             ack_hi,
    output logic             ack_mid,
    output logic             ack_lo,
    output logic [IDX_W-1:0] win_idx
);

    localparam int unsigned OUT_W = BUS_COUNT + IDX_W;

    logic [BUS_COUNT-1:0][LANES-1:0] req_bus;
    logic [BUS_COUNT-1:0][LANES-1:0] live;
    logic [BUS_COUNT-1:0][IDX_W-1:0] bus_idx;
    logic [BUS_COUNT-1:0]            bus_any;
    logic [BUS_COUNT-1:0]            bus_ack;
    logic [IDX_W-1:0]                pick_idx;
    logic [LANES-1:0]                pick_hot;
    logic [OUT_W-1:0]                res_d;
    logic [OUT_W-1:0]                res_q;

    assign req_bus[RANK_HI]  = req_hi;
    assign req_bus[RANK_MID] = req_mid;
    assign req_bus[RANK_LO]  = req_lo;

    generate
        for (genvar b = 0; b < BUS_COUNT; b++) begin : g_bus
            assign live[b] = req_bus[b] & lane_en;

            irq_prio_enc #(
                .LANES (LANES)
            ) u_enc (
                .vec (live[b]),
                .idx (bus_idx[b]),
                .any (bus_any[b])
            );

            assign bus_ack[b] = |(live[b] & pick_hot);
        end
    endgenerate

    irq_bus_pick #(
        .BUSES (BUS_COUNT),
        .IDX_W (IDX_W)
    ) u_pick (
        .bus_idx  (bus_idx),
        .bus_any  (bus_any),
        .pick_idx (pick_idx)
    );

    always_comb begin
        pick_hot = '0;
        for (int i = 0; i < LANES; i++) begin
            pick_hot[i] = (pick_idx == IDX_W'(i));
        end
    end

    assign res_d = {bus_ack[RANK_HI], bus_ack[RANK_MID], bus_ack[RANK_LO], pick_idx};

    irq_out_stage #(
        .REG_OUT (REG_OUT),
        .W       (OUT_W)
    ) u_out (
        .clk (clk),
        .rst (rst),
        .d   (res_d),
        .q   (res_q)
    );

    assign {ack_hi, ack_mid, ack_lo, win_idx} = res_q;

endmodule

// File: rtl/irq_tri_arbiter_chk.sv
module irq_tri_arbiter_chk #(
    parameter int unsigned LANES   = 9,
    parameter bit          REG_OUT = 1'b0,
    parameter int unsigned IDX_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] req_hi,
    input logic [LANES-1:0] req_mid,
    input logic [LANES-1:0] req_lo,
    input logic [LANES-1:0] lane_en,
    input logic             ack_hi,
    input logic             ack_mid,
    input logic             ack_lo,
    input logic [IDX_W-1:0] win_idx
);

    logic [LANES-1:0] d_hi, d_mid, d_lo, d_en;
    logic [LANES-1:0] o_hi, o_mid, o_lo, o_en;
    logic             primed;

    always_ff @(posedge clk) begin
        d_hi  <= req_hi;
        d_mid <= req_mid;
        d_lo  <= req_lo;
        d_en  <= lane_en;
        primed <= rst ? 1'b0 : 1'b1;
    end

    assign o_hi  = REG_OUT ? d_hi  : req_hi;
    assign o_mid = REG_OUT ? d_mid : req_mid;
    assign o_lo  = REG_OUT ? d_lo  : req_lo;
    assign o_en  = REG_OUT ? d_en  : lane_en;

    function automatic logic bit_at(input logic [LANES-1:0] v, input logic [IDX_W-1:0] k);
        logic r;
        r = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (k == IDX_W'(i)) r = v[i];
        end
        return r;
    endfunction

    // R5: an asserted flag means that bus holds an enabled request on the reported lane
    a_r5_ack_on_lane: assert property (@(posedge clk) disable iff (rst || !primed)
        (ack_hi |-> bit_at(o_hi & o_en, win_idx)) and
        (ack_mid |-> bit_at(o_mid & o_en, win_idx)) and
        (ack_lo |-> bit_at(o_lo & o_en, win_idx)));

    // R2: any enabled top-rank request forces the top-rank flag
    a_r2_top_rank_acked: assert property (@(posedge clk) disable iff (rst || !primed)
        (|(o_hi & o_en)) |-> ack_hi);

    // R7: nothing enabled means all-zero outputs
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst || !primed)
        (((o_hi | o_mid | o_lo) & o_en) == '0) |-> (!ack_hi && !ack_mid && !ack_lo && win_idx == '0));

    // R4: index stays inside the lane range
    a_r4_idx_range: assert property (@(posedge clk) disable iff (rst || !primed)
        win_idx < IDX_W'(LANES));

    // R1: a disabled lane is never the winning lane of an acknowledged bus
    a_r1_masked_lane_silent: assert property (@(posedge clk) disable iff (rst || !primed)
        (ack_hi || ack_mid || ack_lo) |-> bit_at(o_en, win_idx));

    generate
        if (REG_OUT) begin : g_reg_chk
            // R8: reset edge leaves all outputs cleared
            a_r8_reset_clears: assert property (@(posedge clk)
                $past(rst) |-> (!ack_hi && !ack_mid && !ack_lo && win_idx == '0));
        end
    endgenerate

endmodule

bind irq_tri_arbiter irq_tri_arbiter_chk #(
    .LANES   (LANES),
    .REG_OUT (REG_OUT),
    .IDX_W   (IDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_hi  (req_hi),
    .req_mid (req_mid),
    .req_lo  (req_lo),
    .lane_en (lane_en),
    .ack_hi  (ack_hi),
    .ack_mid (ack_mid),
    .ack_lo  (ack_lo),
    .win_idx (win_idx)
);

// File: tb/irq_tri_arbiter_tb.sv
module irq_tri_arbiter_tb;

    localparam int LANES = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] req_hi = '0, req_mid = '0, req_lo = '0, lane_en = '0;
    logic             c_hi, c_mid, c_lo, r_hi, r_mid, r_lo;
    logic [3:0]       c_idx, r_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_tri_arbiter #(.LANES(LANES), .REG_OUT(1'b0)) u_dut (
        .clk(clk), .rst(rst), .req_hi(req_hi), .req_mid(req_mid), .req_lo(req_lo),
        .lane_en(lane_en), .ack_hi(c_hi), .ack_mid(c_mid), .ack_lo(c_lo), .win_idx(c_idx));

    irq_tri_arbiter #(.LANES(LANES), .REG_OUT(1'b1)) u_dut_reg (
        .clk(clk), .rst(rst), .req_hi(req_hi), .req_mid(req_mid), .req_lo(req_lo),
        .lane_en(lane_en), .ack_hi(r_hi), .ack_mid(r_mid), .ack_lo(r_lo), .win_idx(r_idx));

    // Reference: returns {ack_hi, ack_mid, ack_lo, idx[3:0]}
    function automatic logic [6:0] model(input logic [8:0] a, input logic [8:0] b,
                                         input logic [8:0] c, input logic [8:0] e);
        logic [8:0] ma, mb, mc, src;
        int w;
        ma = a & e; mb = b & e; mc = c & e;
        src = (ma != 0) ? ma : (mb != 0) ? mb : mc;
        w = 0;
        for (int i = 0; i < 9; i++) if (src[i]) w = i;
        return {ma[w], mb[w], mc[w], 4'(w)};
    endfunction

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b expected=%b hi=%h mid=%h lo=%h en=%h",
                     tag, got, exp, req_hi, req_mid, req_lo, lane_en);
        end
    endtask

    // Drive at a falling edge, check the combinational instance right away,
    // then one rising edge later check the registered instance.
    task automatic apply(input string tag, input logic [8:0] a, input logic [8:0] b,
                         input logic [8:0] c, input logic [8:0] e);
        logic [6:0] exp;
        req_hi = a; req_mid = b; req_lo = c; lane_en = e;
        exp = model(a, b, c, e);
        #1;
        check({tag, " R9 comb"}, {c_hi, c_mid, c_lo, c_idx}, exp);
        @(negedge clk);
        check({tag, " R8 reg"}, {r_hi, r_mid, r_lo, r_idx}, exp);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        req_hi = '1; req_mid = '1; req_lo = '1; lane_en = '1;
        repeat (3) @(negedge clk);
        check("R8 reset state", {r_hi, r_mid, r_lo, r_idx}, 7'd0);
        rst = 1'b0;

        // R6 worked example
        apply("R6 example", 9'b000010100, 9'b001000000, 9'b000010000, '1);
        check("R6 literal", {c_hi, c_mid, c_lo, c_idx}, {3'b101, 4'd4});

        // R7 idle and R1 full mask
        apply("R7 idle", '0, '0, '0, '1);
        apply("R1 all masked", '1, '1, '1, '0);
        check("R7 masked literal", {c_hi, c_mid, c_lo, c_idx}, 7'd0);

        // R4 all set: all three acked at lane 8
        apply("R4 all set", '1, '1, '1, '1);
        check("R5 all set literal", {c_hi, c_mid, c_lo, c_idx}, {3'b111, 4'd8});

        // Single requests under three enable patterns (R1, R3, R4)
        for (int bus = 0; bus < 3; bus++) begin
            for (int l = 0; l < LANES; l++) begin
                logic [8:0] one;
                one = 9'(1) << l;
                apply("R3 single", bus == 0 ? one : '0, bus == 1 ? one : '0,
                      bus == 2 ? one : '0, '1);
                apply("R1 own lane only", bus == 0 ? one : '0, bus == 1 ? one : '0,
                      bus == 2 ? one : '0, one);
                apply("R1 own lane off", bus == 0 ? one : '0, bus == 1 ? one : '0,
                      bus == 2 ? one : '0, ~one);
            end
        end

        // All ordered pairs of request lines (R2, R3, R5)
        for (int p = 0; p < 27; p++) begin
            for (int q = 0; q < 27; q++) begin
                logic [26:0] v;
                v = (27'(1) << p) | (27'(1) << q);
                apply("R2 pair", v[8:0], v[17:9], v[26:18], '1);
            end
        end

        // Random vectors with random enables (R1, R2, R5)
        for (int n = 0; n < 2000; n++) begin
            apply("R5 random", 9'($urandom), 9'($urandom), 9'($urandom), 9'($urandom));
        end

        // R8: reset mid-run clears the registered outputs
        req_hi = '1; lane_en = '1;
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset mid-run", {r_hi, r_mid, r_lo, r_idx}, 7'd0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule